// File: doc/BRIEF.md
# Serial NOR Flash Sector Writer

This block fills whole sectors of a serial NOR flash from a stream of bytes. A start command names a sector. The block waits until the flash is idle, enables writing and erases that sector. It then takes data bytes over a valid/ready handshake and places them in the sector in order, starting at offset zero. The flash accepts at most one 256-byte page per program command, so the block closes the open command whenever a page fills. Before the next byte is accepted, it issues a new write-enable and program sequence for the following page. Status polling and command overhead stall the byte stream by dropping the ready signal.

A next-sector command closes any open command and erases the sector after the current one, so a caller can stream several sectors in a row. A finish command releases the chip select after the final byte, and the flash then commits the last page. A start that arrives while a program command is still open is refused with a pending error code. A status poll that never sees the flash go idle aborts the session with a timeout error code.

The flash link is SPI mode 0, sent most significant bit first. One serial bit takes two system clocks.

Top module: `flash_sector_writer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, cmd_ready is 1, din_ready is 0 and err_code is 0.
- R2: An accepted start (cmd_mode 0) or next-sector (cmd_mode 1) runs three frames: a status poll, then opcode 0x06 alone, then the erase opcode (default 0xD8) followed by the three address bytes page[15:8], page[7:0], 0x00. Here page is the sector number shifted left by SECTOR_SHIFT-8 and truncated to 16 bits. Chip select stays high for at least GAP_CYC clocks before every frame.
- R3: A status poll frame sends 0x05 and then reads status bytes in the same frame for as long as bit 0 of the status byte read is 1. No erase or page program is sent while the flash reports busy, and each one is preceded by a frame holding 0x06.
- R4: The serial clock pulses only while chip select is low. Bits go out most significant first, are driven while the clock is low, and are sampled by the flash on the rising edge.
- R5: Before the first byte of each 256-byte page, the block sends a status poll, then 0x06, then a program frame holding 0x02, page[15:8], page[7:0], 0x00. The data bytes follow in that same frame. When the 256th byte of a page has been sent, chip select rises at once and the page index increments, so a stream that crosses a page boundary splits into two program frames.
- R6: din_ready is 1 only while a program frame is open and no command is being offered. It falls for the whole 16-clock transfer of each accepted byte, and during polling and command overhead.
- R7: A start received while chip select is low sets err_code to 4 and changes nothing else: the open frame and the byte position are kept.
- R8: If POLL_MAX consecutive status reads all show busy, err_code becomes 2, chip select rises, and the session closes with cmd_ready 1 and din_ready 0. No pending byte is taken.
- R9: Next-sector closes any open frame and erases sector+1. Bytes that follow go to offset 0 of that sector.
- R10: A finish command (cmd_mode 2) raises chip select on the cycle after it is accepted and ends the session. When the last page is already full, no further frame is sent.
- R11: err_code is 0 for no error, 2 for a poll timeout and 4 for a refused start. It returns to 0 when a start or next-sector is accepted.
- R12: cmd_mode 3 is accepted and ignored: err_code, chip select and the frame sequence do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle or between bytes) |
| cmd_mode | input | 2 | 0 start, 1 next sector, 2 finish, 3 no operation |
| cmd_sector | input | SECT_W | Sector number used by start |
| din_valid | input | 1 | Data byte offered |
| din_ready | output | 1 | Data byte can be taken |
| din_data | input | 8 | Data byte |
| err_code | output | 3 | Result of the last command or burst |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that the serial input changes only while the clock is low. They also assume the caller drops cmd_valid and din_valid on the cycle after each handshake, so that no command is repeated by accident. The bench's flash model meets the first assumption by changing its output only on falling clock edges. Its drive tasks meet the second by raising a valid between edges and lowering it one cycle after acceptance. The model reports busy only for a fixed number of status reads after each erase or page program. The one exception is the timeout scenario, where the model is held busy on purpose.

// File: rtl/flash_sector_writer.sv
module flash_sector_writer #(
  parameter int          SECT_W       = 16,
  parameter int          SECTOR_SHIFT = 16,
  parameter logic [7:0]  ERASE_OP     = 8'hD8,
  parameter int          GAP_CYC      = 8,
  parameter int          POLL_MAX     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_mode,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  output logic [2:0]        err_code,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PG_SH = SECTOR_SHIFT - 8;
  localparam int GW    = $clog2(GAP_CYC + 1);
  localparam int PW    = $clog2(POLL_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_POLLC, S_POLLR, S_WREN, S_OPC, S_A2, S_A1, S_A0, S_OPEN, S_DATA
  } st_t;

  st_t               st, gap_to;
  logic [3:0]        ph;
  logic [7:0]        tx, sel_byte;
  logic [GW-1:0]     gcnt;
  logic [PW-1:0]     pcnt;
  logic [15:0]       page;
  logic [7:0]        ofs;
  logic [SECT_W-1:0] sect, tgt;
  logic              need_pp, is_erase, shifting, byte_end, cmd_go, din_go;

  function automatic logic [15:0] first_page(input logic [SECT_W-1:0] s);
    first_page = 16'(s) << PG_SH;
  endfunction

  assign shifting  = st inside {S_POLLC, S_POLLR, S_WREN, S_OPC, S_A2, S_A1, S_A0, S_DATA};
  assign byte_end  = shifting && (ph == 4'd15);
  assign spi_sck   = shifting && ph[0];
  assign spi_mosi  = shifting && tx[7];
  assign cmd_ready = (st == S_IDLE) || (st == S_OPEN);
  assign din_ready = (st == S_OPEN) && !need_pp && !cmd_valid;
  assign cmd_go    = cmd_valid && cmd_ready;
  assign din_go    = din_valid && din_ready;
  assign tgt       = (cmd_mode == 2'd1) ? sect + 1'b1 : cmd_sector;

  always_comb
    case (gap_to)
      S_POLLC: sel_byte = 8'h05;
      S_WREN:  sel_byte = 8'h06;
      default: sel_byte = is_erase ? ERASE_OP : 8'h02;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gap_to <= S_POLLC; ph <= '0; tx <= '0; gcnt <= '0; pcnt <= '0;
      page <= '0; ofs <= '0; sect <= '0; need_pp <= 1'b0; is_erase <= 1'b0;
      err_code <= 3'd0; spi_cs_n <= 1'b1;
    end else begin
      ph <= shifting ? ph + 4'd1 : 4'd0;
      if (shifting && ph[0]) tx <= {tx[6:0], 1'b0};
      case (st)
        S_IDLE, S_OPEN: begin
          if (cmd_go) begin
            if (cmd_mode == 2'd0 && !spi_cs_n) begin
              err_code <= 3'd4;
            end else if (cmd_mode == 2'd0 || cmd_mode == 2'd1) begin
              sect <= tgt; page <= first_page(tgt); ofs <= '0;
              need_pp <= 1'b0; is_erase <= 1'b1; err_code <= 3'd0;
              spi_cs_n <= 1'b1; pcnt <= '0; gcnt <= '0;
              gap_to <= S_POLLC; st <= S_GAP;
            end else if (cmd_mode == 2'd2) begin
              spi_cs_n <= 1'b1; need_pp <= 1'b0; st <= S_IDLE;
            end
          end else if (st == S_OPEN && din_valid && need_pp) begin
            is_erase <= 1'b0; pcnt <= '0; gcnt <= '0;
            gap_to <= S_POLLC; st <= S_GAP;
          end else if (din_go) begin
            tx <= din_data; st <= S_DATA;
          end
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CYC)) begin
            spi_cs_n <= 1'b0; tx <= sel_byte; st <= gap_to;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_POLLC: if (byte_end) begin tx <= 8'h00; st <= S_POLLR; end
        S_POLLR: if (byte_end) begin
          if (!spi_miso) begin
            spi_cs_n <= 1'b1; gcnt <= '0; gap_to <= S_WREN; st <= S_GAP;
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            err_code <= 3'd2; spi_cs_n <= 1'b1; need_pp <= 1'b0; st <= S_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_WREN: if (byte_end) begin
          spi_cs_n <= 1'b1; gcnt <= '0; gap_to <= S_OPC; st <= S_GAP;
        end
        S_OPC: if (byte_end) begin tx <= page[15:8]; st <= S_A2; end
        S_A2:  if (byte_end) begin tx <= page[7:0];  st <= S_A1; end
        S_A1:  if (byte_end) begin tx <= 8'h00;      st <= S_A0; end
        S_A0: if (byte_end) begin
          st <= S_OPEN;
          if (is_erase) begin spi_cs_n <= 1'b1; need_pp <= 1'b1; end
          else need_pp <= 1'b0;
        end
        S_DATA: if (byte_end) begin
          ofs <= ofs + 8'd1; st <= S_OPEN;
          if (ofs == 8'hFF) begin
            page <= page + 16'd1; spi_cs_n <= 1'b1; need_pp <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_sector_writer_chk.sv
module flash_sector_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_mode,
  input logic       din_valid,
  input logic       din_ready,
  input logic [2:0] err_code,
  input logic       spi_cs_n,
  input logic       spi_sck
);
  // R4
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

  // R6
  din_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !spi_cs_n);

  // R6
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=> !din_ready);

  // R11
  err_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 3'd0) || (err_code == 3'd2) || (err_code == 3'd4));

  // R7
  pend_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == 2'd0 && !spi_cs_n) |=> (err_code == 3'd4 && !spi_cs_n));

  // R10
  finish_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == 2'd2) |=> (spi_cs_n && !din_ready));

  // R12
  nop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == 2'd3) |=> ($stable(err_code) && $stable(spi_cs_n)));
endmodule

bind flash_sector_writer flash_sector_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_mode(cmd_mode), .din_valid(din_valid), .din_ready(din_ready),
  .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/tb_flash_sector_writer.sv
`timescale 1ns/1ps
module tb_flash_sector_writer;
  localparam int GAP = 8, PMAX = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, din_valid = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic [15:0] cmd_sector = '0;
  logic [7:0] din_data = '0;
  logic cmd_ready, din_ready, spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic [2:0] err_code;
  logic miso_r = 1'b0;
  assign spi_miso = miso_r;

  always #2 clk = ~clk;

  flash_sector_writer #(.GAP_CYC(GAP), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_sector(cmd_sector), .din_valid(din_valid),
    .din_ready(din_ready), .din_data(din_data), .err_code(err_code),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, errors = 0, cyc = 0;

  // flash model
  bit in_frame = 0, busy_forever = 0, wel = 0, busy_sel = 0;
  int bitc, bytec, busy_cnt = 0, proto_err = 0, gap_err = 0, nfrm = 0;
  logic [7:0] sr, op, b1, b2, b3;
  logic [7:0] f_op [64], f_b1 [64], f_b2 [64], f_b3 [64];
  int f_len [64];
  logic [7:0] mem [int];
  realtime rise_t = -1000.0;

  always @(negedge spi_cs_n) begin
    in_frame = 1; bitc = 0; bytec = 0; miso_r = 1'b0;
    if ($realtime - rise_t < GAP * 4.0) gap_err++;
    busy_sel = (busy_cnt > 0) || busy_forever;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    sr = {sr[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) op = sr;
      else if (bytec == 1) b1 = sr;
      else if (bytec == 2) b2 = sr;
      else if (bytec == 3) b3 = sr;
      else if (op == 8'h02) mem[int'({b1, b2, b3}) + bytec - 4] = sr;
      if (op == 8'h05 && bytec >= 1 && busy_cnt > 0) busy_cnt--;
      bytec++;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n)
    miso_r = (bitc == 7) && (op == 8'h05) && (bytec >= 1) && (busy_cnt > 0 || busy_forever);

  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0; rise_t = $realtime; miso_r = 1'b0;
    if (nfrm < 64) begin
      f_op[nfrm] = op; f_b1[nfrm] = b1; f_b2[nfrm] = b2; f_b3[nfrm] = b3; f_len[nfrm] = bytec;
    end
    nfrm++;
    if (op != 8'h05 && busy_sel) proto_err++;
    if (op == 8'h06) wel = 1;
    else if (op == 8'hD8 || op == 8'h02) begin
      if (!wel) proto_err++;
      wel = 0;
      busy_cnt = (op == 8'hD8) ? 3 : 2;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] m, input logic [15:0] s);
    @(negedge clk); cmd_valid = 1'b1; cmd_mode = m; cmd_sector = s;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    @(negedge clk); din_valid = 1'b1; din_data = v;
    while (!din_ready) @(negedge clk);
    @(negedge clk); din_valid = 1'b0;
  endtask

  task automatic send_bytes(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) send_byte(8'(base + i));
  endtask

  task automatic wait_ready();
    int t = 0;
    @(negedge clk);
    while (!cmd_ready && t < 50000) begin @(negedge clk); t++; end
    if (!cmd_ready) chk("R2", "cmd_ready timeout", 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_mem(input string req, input int addr, input int n, input logic [7:0] base);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (!mem.exists(addr + i) || mem[addr + i] != 8'(base + i)) bad++;
    chk(req, "data bytes mismatching", bad, 0);
  endtask

  task automatic chk_frame(input string req, input int i, input logic [7:0] o,
                           input logic [7:0] a, input logic [7:0] b, input int len);
    chk(req, $sformatf("frame %0d opcode", i), f_op[i], o);
    chk(req, $sformatf("frame %0d addr", i), {f_b1[i], f_b2[i], f_b3[i]}, {a, b, 8'h00});
    chk(req, $sformatf("frame %0d length", i), f_len[i], len);
  endtask

  task automatic t_reset();
    chk("R1", "cs_n", spi_cs_n, 1);
    chk("R1", "sck", spi_sck, 0);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "din_ready", din_ready, 0);
    chk("R1", "err_code", err_code, 0);
  endtask

  task automatic t_basic();
    nfrm = 0;
    send_cmd(2'd0, 16'd3); wait_ready();
    chk("R2", "frames after start", nfrm, 3);
    chk("R2", "poll opcode", f_op[0], 8'h05);
    chk("R2", "wren opcode", f_op[1], 8'h06);
    chk_frame("R2", 2, 8'hD8, 8'h03, 8'h00, 4);
    chk("R6", "din_ready before page program", din_ready, 0);
    send_bytes(4, 8'hA0);
    send_cmd(2'd2, 16'd0); wait_ready();
    chk("R10", "frames after finish", nfrm, 6);
    chk("R3", "poll frame length while erase busy", f_len[3], 5);
    chk("R5", "wren before program", f_op[4], 8'h06);
    chk_frame("R5", 5, 8'h02, 8'h03, 8'h00, 8);
    chk_mem("R4", 32'h030000, 4, 8'hA0);
    chk("R11", "err_code", err_code, 0);
  endtask

  task automatic t_split();
    nfrm = 0;
    send_cmd(2'd0, 16'd5); wait_ready();
    send_bytes(300, 8'h10);
    send_cmd(2'd2, 16'd0); wait_ready();
    chk("R5", "frames for split burst", nfrm, 9);
    chk_frame("R5", 5, 8'h02, 8'h05, 8'h00, 260);
    chk("R3", "poll after program", f_op[6], 8'h05);
    chk_frame("R5", 8, 8'h02, 8'h05, 8'h01, 48);
    chk_mem("R5", 32'h050000, 300, 8'h10);
  endtask

  task automatic t_exact();
    nfrm = 0;
    send_cmd(2'd0, 16'd9); wait_ready();
    send_bytes(256, 8'h33);
    idle(20);
    chk("R5", "cs_n after full page", spi_cs_n, 1);
    chk("R5", "frames after full page", nfrm, 6);
    chk("R6", "din_ready with page program needed", din_ready, 0);
    send_cmd(2'd2, 16'd0); wait_ready();
    chk("R10", "no extra frame on finish", nfrm, 6);
    chk_mem("R5", 32'h090000, 256, 8'h33);
  endtask

  task automatic t_pending();
    nfrm = 0;
    send_cmd(2'd0, 16'd2); wait_ready();
    send_bytes(3, 8'h70);
    idle(20);
    chk("R7", "frames before refused start", nfrm, 5);
    send_cmd(2'd0, 16'd40);
    chk("R7", "err_code after refused start", err_code, 4);
    chk("R7", "cs_n held low", spi_cs_n, 0);
    idle(10);
    chk("R7", "no frame closed", nfrm, 5);
    send_byte(8'h73);
    send_cmd(2'd2, 16'd0); wait_ready();
    chk_frame("R7", 5, 8'h02, 8'h02, 8'h00, 8);
    chk_mem("R7", 32'h020000, 4, 8'h70);
  endtask

  task automatic t_next();
    nfrm = 0;
    send_cmd(2'd0, 16'd7); wait_ready();
    chk("R11", "err_code cleared by start", err_code, 0);
    send_bytes(10, 8'h01);
    send_cmd(2'd1, 16'd0); wait_ready();
    chk("R9", "frames after next sector", nfrm, 9);
    chk("R9", "program frame closed", f_len[5], 14);
    chk_frame("R9", 8, 8'hD8, 8'h08, 8'h00, 4);
    send_bytes(2, 8'hC0);
    send_cmd(2'd2, 16'd0); wait_ready();
    chk_frame("R9", 11, 8'h02, 8'h08, 8'h00, 6);
    chk_mem("R9", 32'h080000, 2, 8'hC0);
  endtask

  task automatic t_timeout();
    int t = 0;
    nfrm = 0;
    send_cmd(2'd0, 16'd1); wait_ready();
    @(negedge clk); busy_forever = 1; din_valid = 1'b1; din_data = 8'h55;
    while (err_code == 3'd0 && t < 20000) begin @(negedge clk); t++; end
    chk("R8", "err_code on timeout", err_code, 2);
    chk("R8", "cs_n after timeout", spi_cs_n, 1);
    chk("R8", "cmd_ready after timeout", cmd_ready, 1);
    chk("R8", "din_ready after timeout", din_ready, 0);
    idle(40);
    chk("R8", "frames after timeout", nfrm, 4);
    chk("R8", "poll frame length", f_len[3], 1 + PMAX);
    chk("R8", "pending byte not written", mem.exists(32'h010000), 0);
    din_valid = 1'b0; busy_forever = 0; busy_cnt = 0;
  endtask

  task automatic t_ignore();
    int n0 = nfrm;
    send_cmd(2'd3, 16'd0);
    idle(20);
    chk("R12", "err_code kept", err_code, 2);
    chk("R12", "cmd_ready", cmd_ready, 1);
    chk("R12", "no frame", nfrm, n0);
    chk("R12", "cs_n", spi_cs_n, 1);
    send_cmd(2'd0, 16'd0); wait_ready();
    chk("R11", "err_code cleared after timeout", err_code, 0);
    send_cmd(2'd2, 16'd0); wait_ready();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_split();
    t_exact();
    t_pending();
    t_next();
    t_timeout();
    t_ignore();
    chk("R3", "protocol violations", proto_err, 0);
    chk("R2", "short deselect gaps", gap_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule